// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Takeover

This block is an eight-pin general-purpose I/O port. Software reaches three registers over a small register bus: a direction register, an output latch, and a pin-state register that returns the synchronized pad levels. Every pin has three override pairs, one each for direction, output value and pull-up. Each pair is an enable and a value. When an enable is set, the value takes over from the register-driven path. The register bits stay intact and readable the whole time.

Two sources feed the override pairs. The first is a static clock configuration, which stands in for non-volatile option bits. When it selects a crystal oscillator, it claims the two top pins, 7 and 6. The second is a serial-peripheral enable, which hands pins 5 down to 3 to a peripheral. The peripheral supplies its own per-pin direction and data. Pin 2 and the pins below it always stay under port control. The pad-side outputs are registered, so each one changes one clock after its cause.

Top module: `gpio_ovr_port`

## Requirements
- R1: After synchronous reset the direction and latch registers read 0, and `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R2: For a pin with no direction or output override, `pad_oe` equals its direction bit. `pad_out` equals the latch bit when the pin is an output and 0 otherwise.
- R3: Pins 7 and 6 are taken over when (`clk_sel_rc`==0 and `clk_sel_ext`==0) or `async_tmr_sel`==1. While taken over, their `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R4: Writes to the latch (address 2) are stored and read back unchanged, including the bits of pins that are taken over.
- R5: When a takeover is released, the pin's pad outputs return to its stored direction and latch bits on the next clock.
- R6: While `spi_en`==1, `pad_oe[5:3]` equals `spi_oe[2:0]` and `pad_out[5:3]` equals `spi_oe & spi_do`. Pin 2 stays under the port registers.
- R7: A whole-byte latch write of 0xFF changes only the pins that are not taken over.
- R8: `pad_pu` is 1 only when the pin's effective direction is input, its latch bit is 1, no pull-up override is active, and `pu_disable`==0. A taken-over crystal pin forces a pull-up of 0.
- R9: Address 0 returns `pad_in` through a two-stage synchronizer, whether or not a pin is taken over. A read issued on the clock after a pad change still returns the old level.
- R10: Register map: address 0 pin state (read-only, writes ignored), address 1 direction, address 2 latch, address 3 reads 0. `rdata` loads on the clock edge where `rd_en` is sampled.
- R11: Pad outputs are registered. A direction write becomes visible on `pad_oe` one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| clk_sel_rc | input | 1 | Clock configuration: internal RC selected |
| clk_sel_ext | input | 1 | Clock configuration: external clock selected |
| async_tmr_sel | input | 1 | Asynchronous timer clocked from the crystal pins |
| spi_en | input | 1 | Serial peripheral owns pins 5..3 |
| spi_oe | input | 3 | Peripheral direction for pins 5..3 (bit 0 = pin 3) |
| spi_do | input | 3 | Peripheral data for pins 5..3 (bit 0 = pin 3) |
| pu_disable | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Pad levels |
| pad_oe | output | 8 | Output driver enables |
| pad_out | output | 8 | Driven levels |
| pad_pu | output | 8 | Pull-up enables |

## Verification
The bench builds the port with its defaults: eight pins, the crystal pair at 6, the peripheral group at 3 with three pins, and two synchronizer stages. With these values, both takeover sources can act on the same byte together with the free pins 2..0. That lets one vector show the crystal pins forced off, the peripheral pins following their own direction and data, and pin 2 still obeying the registers. A synchronizer of exactly two stages also makes the stale first read after a pad change observable.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  typedef enum logic [1:0] {
    REG_PIN = 2'd0,
    REG_DIR = 2'd1,
    REG_LAT = 2'd2,
    REG_RSV = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic dd_oe;
    logic dd_ov;
    logic pv_oe;
    logic pv_ov;
    logic pu_oe;
    logic pu_ov;
  } pin_ovr_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] rdata
);
  reg_sel_e sel;
  logic [WIDTH-1:0] rd_mux;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lat_q <= '0;
    end else if (wr_en) begin
      if (sel == REG_DIR) dir_q <= wdata;
      if (sel == REG_LAT) lat_q <= wdata;
    end
  end

  always_comb begin
    case (sel)
      REG_PIN: rd_mux = pin_sync;
      REG_DIR: rd_mux = dir_q;
      REG_LAT: rd_mux = lat_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_ovr_src.sv
module gpio_ovr_src
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int XTAL_LO = 6,
  parameter int SPI_LO  = 3,
  parameter int SPI_N   = 3
) (
  input  logic                 clk_sel_rc,
  input  logic                 clk_sel_ext,
  input  logic                 async_tmr_sel,
  input  logic                 spi_en,
  input  logic [SPI_N-1:0]     spi_oe,
  input  logic [SPI_N-1:0]     spi_do,
  output pin_ovr_t [WIDTH-1:0] ovr
);
  localparam int XTAL_HI = XTAL_LO + 1;
  localparam int SPI_HI  = SPI_LO + SPI_N - 1;

  logic xtal_take;
  assign xtal_take = (!clk_sel_rc && !clk_sel_ext) || async_tmr_sel;

  for (genvar i = 0; i < WIDTH; i++) begin : g_src
    if (i >= XTAL_LO && i <= XTAL_HI) begin : g_xtal
      // crystal pins: driver and pull-up forced off
      assign ovr[i] = {xtal_take, 1'b0, xtal_take, 1'b0, xtal_take, 1'b0};
    end else if (i >= SPI_LO && i <= SPI_HI) begin : g_spi
      assign ovr[i] = {spi_en, spi_oe[i-SPI_LO], spi_en, spi_do[i-SPI_LO], 1'b0, 1'b0};
    end else begin : g_free
      assign ovr[i] = '0;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pu_disable,
  input  logic [WIDTH-1:0]     dir_q,
  input  logic [WIDTH-1:0]     lat_q,
  input  pin_ovr_t [WIDTH-1:0] ovr,
  output logic [WIDTH-1:0]     pad_oe,
  output logic [WIDTH-1:0]     pad_out,
  output logic [WIDTH-1:0]     pad_pu
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic dir_e, out_e, pu_e;
    logic oe_q, out_q, pu_q;

    always_comb begin
      dir_e = ovr[i].dd_oe ? ovr[i].dd_ov : dir_q[i];
      out_e = ovr[i].pv_oe ? ovr[i].pv_ov : lat_q[i];
      if (pu_disable)      pu_e = 1'b0;
      else if (ovr[i].pu_oe) pu_e = ovr[i].pu_ov;
      else                 pu_e = !dir_e && lat_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        oe_q  <= 1'b0;
        out_q <= 1'b0;
        pu_q  <= 1'b0;
      end else begin
        oe_q  <= dir_e;
        out_q <= dir_e & out_e;
        pu_q  <= pu_e;
      end
    end

    assign pad_oe[i]  = oe_q;
    assign pad_out[i] = out_q;
    assign pad_pu[i]  = pu_q;
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int XTAL_LO     = 6,
  parameter int SPI_LO      = 3,
  parameter int SPI_N       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             clk_sel_rc,
  input  logic             clk_sel_ext,
  input  logic             async_tmr_sel,
  input  logic             spi_en,
  input  logic [SPI_N-1:0] spi_oe,
  input  logic [SPI_N-1:0] spi_do,
  input  logic             pu_disable,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  pin_ovr_t [WIDTH-1:0] ovr;

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pin_sync(pin_sync), .dir_q(dir_q), .lat_q(lat_q),
    .rdata(rdata)
  );

  gpio_ovr_src #(.WIDTH(WIDTH), .XTAL_LO(XTAL_LO), .SPI_LO(SPI_LO), .SPI_N(SPI_N)) u_src (
    .clk_sel_rc(clk_sel_rc), .clk_sel_ext(clk_sel_ext),
    .async_tmr_sel(async_tmr_sel), .spi_en(spi_en),
    .spi_oe(spi_oe), .spi_do(spi_do), .ovr(ovr)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rst(rst), .pu_disable(pu_disable), .dir_q(dir_q),
    .lat_q(lat_q), .ovr(ovr), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu)
  );
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int WIDTH   = 8,
  parameter int XTAL_LO = 6,
  parameter int SPI_LO  = 3,
  parameter int SPI_N   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic             clk_sel_rc,
  input logic             clk_sel_ext,
  input logic             async_tmr_sel,
  input logic             spi_en,
  input logic [SPI_N-1:0] spi_oe,
  input logic             pu_disable,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] lat_q,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pu
);
  p_xtal_off_r3: assert property (@(posedge clk) disable iff (rst)
    ((!clk_sel_rc && !clk_sel_ext) || async_tmr_sel) |=>
      (pad_oe[XTAL_LO +: 2] == 2'b00 && pad_pu[XTAL_LO +: 2] == 2'b00));

  p_spi_dir_r6: assert property (@(posedge clk) disable iff (rst)
    spi_en |=> pad_oe[SPI_LO +: SPI_N] == $past(spi_oe));

  p_free_dir_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pad_oe[SPI_LO-1:0] == $past(dir_q[SPI_LO-1:0]));

  p_out_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  p_pu_off_r8: assert property (@(posedge clk) disable iff (rst)
    pu_disable |=> pad_pu == '0);

  p_lat_store_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd2) |=> lat_q == $past(wdata));

  p_rd_lat_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd2) |=> rdata == $past(lat_q));

  p_rd_rsv_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd3) |=> rdata == '0);
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .WIDTH(WIDTH), .XTAL_LO(XTAL_LO), .SPI_LO(SPI_LO), .SPI_N(SPI_N)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .clk_sel_rc(clk_sel_rc),
  .clk_sel_ext(clk_sel_ext), .async_tmr_sel(async_tmr_sel),
  .spi_en(spi_en), .spi_oe(spi_oe), .pu_disable(pu_disable),
  .dir_q(dir_q), .lat_q(lat_q), .pad_oe(pad_oe), .pad_out(pad_out),
  .pad_pu(pad_pu)
);

// File: tb/gpio_ovr_port_bench.sv
module gpio_ovr_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic       clk_sel_rc = 1'b1, clk_sel_ext = 1'b0, async_tmr_sel = 1'b0;
  logic       spi_en = 1'b0, pu_disable = 1'b0;
  logic [2:0] spi_oe = 3'b000, spi_do = 3'b000;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  gpio_ovr_port u_gpio_ovr_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_sel_rc(clk_sel_rc),
    .clk_sel_ext(clk_sel_ext), .async_tmr_sel(async_tmr_sel),
    .spi_en(spi_en), .spi_oe(spi_oe), .spi_do(spi_do),
    .pu_disable(pu_disable), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // {cfg{rc,ext,async,spi}, spi_oe, spi_do, dir, lat, exp_oe, exp_out, exp_pu}
  localparam logic [49:0] VEC [0:6] = '{
    {4'b1000, 3'b000, 3'b000, 8'hF0, 8'hAA, 8'hF0, 8'hA0, 8'h0A},
    {4'b1000, 3'b000, 3'b000, 8'h0F, 8'hFF, 8'h0F, 8'h0F, 8'hF0},
    {4'b0000, 3'b000, 3'b000, 8'hFF, 8'hFF, 8'h3F, 8'h3F, 8'h00},
    {4'b1010, 3'b000, 3'b000, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h3F},
    {4'b1001, 3'b101, 3'b111, 8'h00, 8'hFF, 8'h28, 8'h28, 8'hD7},
    {4'b0101, 3'b010, 3'b000, 8'hFF, 8'h00, 8'hD7, 8'h00, 8'h00},
    {4'b0001, 3'b111, 3'b010, 8'h04, 8'hFF, 8'h3C, 8'h14, 8'h03}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {clk_sel_rc, clk_sel_ext, async_tmr_sel, spi_en} = c;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    rd(2'd1, rv); check("R1 dir", rv, 8'h00);
    rd(2'd2, rv); check("R1 lat", rv, 8'h00);

    // table: R2 R3 R6 R8
    for (int k = 0; k < 7; k++) begin
      set_cfg(VEC[k][49:46]);
      spi_oe = VEC[k][45:43];
      spi_do = VEC[k][42:40];
      wr(2'd1, VEC[k][39:32]);
      wr(2'd2, VEC[k][31:24]);
      @(negedge clk); @(negedge clk);
      check($sformatf("R2/R3/R6 vec%0d oe", k), pad_oe, VEC[k][23:16]);
      check($sformatf("R2/R3/R6 vec%0d out", k), pad_out, VEC[k][15:8]);
      check($sformatf("R8 vec%0d pu", k), pad_pu, VEC[k][7:0]);
    end

    // R4 R7: crystal pins taken over, whole-byte writes
    set_cfg(4'b0000); spi_oe = 3'b000; spi_do = 3'b000;
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'hFF);
    @(negedge clk);
    check("R7 out after 0xFF", pad_out, 8'h3F);
    check("R7 oe after 0xFF", pad_oe, 8'h3F);
    rd(2'd2, rv); check("R4 latch readback", rv, 8'hFF);

    // R5: release takeover, stored bits return next clock
    @(negedge clk);
    clk_sel_rc = 1'b1;
    @(negedge clk);
    check("R5 oe after release", pad_oe, 8'hFF);
    check("R5 out after release", pad_out, 8'hFF);

    // R6: pin 2 stays with the port while the peripheral is on
    spi_en = 1'b1; spi_oe = 3'b000;
    @(negedge clk);
    check("R6 pin2 oe", {7'b0, pad_oe[2]}, 8'h01);
    check("R6 pin2 out", {7'b0, pad_out[2]}, 8'h01);
    check("R6 spi pins off", {5'b0, pad_oe[5:3]}, 8'h00);
    spi_en = 1'b0;

    // R8 global pull-up disable
    wr(2'd1, 8'h00);
    pu_disable = 1'b1;
    @(negedge clk);
    check("R8 pu disabled", pad_pu, 8'h00);
    pu_disable = 1'b0;
    @(negedge clk);
    check("R8 pu enabled", pad_pu, 8'hFF);

    // R9 synchronized pin read, also while taken over
    clk_sel_rc = 1'b0;
    pad_in = 8'h5A;
    repeat (3) @(negedge clk);
    rd(2'd0, rv); check("R9 pin read", rv, 8'h5A);
    pad_in = 8'hA5;
    rd(2'd0, rv); check("R9 stale first read", rv, 8'h5A);
    rd(2'd0, rv); check("R9 new level", rv, 8'hA5);

    // R10 map: pin register read-only, address 3 reads 0
    wr(2'd0, 8'hFF);
    rd(2'd0, rv); check("R10 pin ro", rv, 8'hA5);
    rd(2'd3, rv); check("R10 rsv", rv, 8'h00);
    rd(2'd1, rv); check("R10 dir", rv, 8'h00);

    // R11 registered pad outputs
    clk_sel_rc = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h01;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R11 oe not yet", pad_oe, 8'h00);
    @(negedge clk); @(negedge clk);
    check("R11 oe updated", pad_oe, 8'h01);

    finish_run();
  end
endmodule